// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a small 32-bit core whose registers are organised in rotating windows. Software sees 32 architectural registers in four groups of eight: globals (0–7), outs (8–15), locals (16–23) and ins (24–31). Globals are the same physical registers in every window, and every window has eight locals of its own. The ins of one window are the outs of the window next to it. A value placed in a caller's outs therefore appears in the callee's ins once a window is allocated, and no data moves.

The block has two combinational read ports and one write port, all addressed by architectural number. A current-window register and a per-window invalid mask manage the rotation. A save command allocates the next window by stepping the pointer down, and a restore command steps it back up, both modulo the window count. If the target window is marked invalid, the pointer stays where it is and a one-cycle overflow or underflow flag is raised for the trap logic. A control port loads the pointer and the mask directly.

Top module: `regwin_file`

## Requirements
- R1: After reset the window pointer is 0, the invalid mask equals the `WIM_RESET` parameter (default all zeros), both flags are low and every register reads 0.
- R2: Architectural register 0 always reads 0 on both read ports, and writes to it are discarded.
- R3: Registers 1–7 are shared: a value written in one window reads back unchanged in every other window.
- R4: Registers 16–23 are private to each window: a write in window W is not visible in any other window.
- R5: Register 8+k (out k) of window N is the same storage as register 24+k (in k) of window (N−1) mod NUM_WIN.
- R6: `win_cmd` 2'b01 (save) moves the pointer to (CWP−1) mod NUM_WIN and `win_cmd` 2'b10 (restore) moves it to (CWP+1) mod NUM_WIN, on the next clock edge, when the target window is valid.
- R7: A save whose target window has its mask bit at 1 leaves the pointer unchanged and drives `win_overflow` high for exactly the following cycle.
- R8: A restore whose target window has its mask bit at 1 leaves the pointer unchanged and drives `win_underflow` high for exactly the following cycle.
- R9: A read of a nonzero register that is being written in the same cycle returns the write data (write-first bypass).
- R10: `ctl_wr_en` loads `ctl_cwp` and `ctl_wim` on the next edge, and a window command in that same cycle is ignored.
- R11: `win_cmd` 2'b11 and 2'b00 leave the pointer and mask unchanged and raise no flag.
- R12: A register write and a window command in the same cycle address the register through the window that was current before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | XLEN | Write data |
| win_cmd | input | 2 | Window command: 00 none, 01 save, 10 restore, 11 none |
| ctl_wr_en | input | 1 | Load pointer and mask |
| ctl_cwp | input | log2(NUM_WIN) | Pointer value to load |
| ctl_wim | input | NUM_WIN | Invalid mask to load, bit W set marks window W invalid |
| cwp | output | log2(NUM_WIN) | Current window pointer |
| wim | output | NUM_WIN | Current invalid mask |
| win_overflow | output | 1 | One-cycle flag: save refused |
| win_underflow | output | 1 | One-cycle flag: restore refused |

## Verification
The bench builds the block with its defaults: eight windows, 32-bit data and an all-zero reset mask. With eight windows, a run of eight saves carries the pointer through the 0→7 wrap and back to its starting window. Shared outs and ins can then be checked around the full ring, including between windows 0 and 7. Mask loads through the control port place the single invalid window next to the pointer in either direction, so overflow, underflow and control-over-command priority can all be reached within a few cycles.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;
    localparam int unsigned IDX_W      = 5;
    localparam int unsigned GROUP_SIZE = 8;
    localparam int unsigned WIN_SPAN   = 2 * GROUP_SIZE;

    typedef enum logic [1:0] {
        WCMD_NONE    = 2'b00,
        WCMD_SAVE    = 2'b01,
        WCMD_RESTORE = 2'b10,
        WCMD_RSVD    = 2'b11
    } win_cmd_e;

    // Upper two bits of an architectural register number
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_group_e;
endpackage

// File: rtl/wrf_addr_map.sv
`timescale 1ns/1ps
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int unsigned CWP_W  = 3,
    parameter int unsigned PHYS_W = 8
) (
    input  logic [IDX_W-1:0]  arch_idx,
    input  logic [CWP_W-1:0]  cur_win,
    output logic [PHYS_W-1:0] phys_idx
);
    reg_group_e       grp;
    logic [2:0]       slot;
    logic [CWP_W-1:0] bank;
    logic [3:0]       lane;

    // Physical layout: globals at 0..7, then one 16-entry bank per window
    // holding its ins (lane 0..7) and its locals (lane 8..15).
    // Outs resolve to the ins of the window one below.
    always_comb begin
        grp  = reg_group_e'(arch_idx[4:3]);
        slot = arch_idx[2:0];
        bank = cur_win;
        lane = {1'b0, slot};
        unique case (grp)
            GRP_GLOBAL: lane = {1'b0, slot};
            GRP_OUT:    bank = cur_win - CWP_W'(1);
            GRP_LOCAL:  lane = {1'b1, slot};
            GRP_IN:     lane = {1'b0, slot};
        endcase
        if (grp == GRP_GLOBAL) begin
            phys_idx = PHYS_W'(slot);
        end else begin
            phys_idx = PHYS_W'(GROUP_SIZE) + PHYS_W'({bank, lane});
        end
    end
endmodule

// File: rtl/wrf_window_ctrl.sv
`timescale 1ns/1ps
module wrf_window_ctrl
    import wrf_pkg::*;
#(
    parameter int unsigned         NUM_WIN   = 8,
    parameter int unsigned         CWP_W     = 3,
    parameter logic [NUM_WIN-1:0]  WIM_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cmd,
    input  logic               ctl_wr_en,
    input  logic [CWP_W-1:0]   ctl_cwp,
    input  logic [NUM_WIN-1:0] ctl_wim,
    output logic [CWP_W-1:0]   cwp_o,
    output logic [NUM_WIN-1:0] wim_o,
    output logic               ovf_o,
    output logic               unf_o
);
    typedef struct packed {
        logic [CWP_W-1:0]   cwp;
        logic [NUM_WIN-1:0] wim;
        logic               ovf;
        logic               unf;
    } win_state_t;

    win_state_t       state_d, state_q;
    logic [CWP_W-1:0] down_d, up_d;
    win_cmd_e         op;

    always_comb begin
        state_d     = state_q;
        state_d.ovf = 1'b0;
        state_d.unf = 1'b0;
        op          = win_cmd_e'(cmd);
        down_d      = state_q.cwp - CWP_W'(1);
        up_d        = state_q.cwp + CWP_W'(1);
        if (ctl_wr_en) begin
            state_d.cwp = ctl_cwp;
            state_d.wim = ctl_wim;
        end else begin
            unique case (op)
                WCMD_SAVE: begin
                    if (state_q.wim[down_d]) state_d.ovf = 1'b1;
                    else                     state_d.cwp = down_d;
                end
                WCMD_RESTORE: begin
                    if (state_q.wim[up_d]) state_d.unf = 1'b1;
                    else                   state_d.cwp = up_d;
                end
                WCMD_NONE, WCMD_RSVD: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{cwp: '0, wim: WIM_RESET, ovf: 1'b0, unf: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign cwp_o = state_q.cwp;
    assign wim_o = state_q.wim;
    assign ovf_o = state_q.ovf;
    assign unf_o = state_q.unf;
endmodule

// File: rtl/wrf_storage.sv
`timescale 1ns/1ps
module wrf_storage #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned PHYS_N = 136,
    parameter int unsigned PHYS_W = 8,
    parameter int unsigned N_RD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PHYS_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [PHYS_W-1:0] raddr [N_RD],
    output logic [XLEN-1:0]   rdata [N_RD]
);
    logic [XLEN-1:0] mem_d [PHYS_N];
    logic [XLEN-1:0] mem_q [PHYS_N];
    logic            wr_live;

    // Physical entry 0 only ever holds the hard-wired zero register.
    assign wr_live = we && (waddr != '0);

    always_comb begin
        mem_d = mem_q;
        if (wr_live) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == '0) begin
                rdata[p] = '0;
            end else if (wr_live && (waddr == raddr[p])) begin
                rdata[p] = wdata;
            end else begin
                rdata[p] = mem_q[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/regwin_file.sv
`timescale 1ns/1ps
module regwin_file
    import wrf_pkg::*;
#(
    parameter int unsigned        NUM_WIN   = 8,
    parameter int unsigned        XLEN      = 32,
    parameter logic [NUM_WIN-1:0] WIM_RESET = '0,
    localparam int unsigned       CWP_W     = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         rd_a_idx,
    output logic [XLEN-1:0]    rd_a_data,
    input  logic [4:0]         rd_b_idx,
    output logic [XLEN-1:0]    rd_b_data,
    input  logic               wr_en,
    input  logic [4:0]         wr_idx,
    input  logic [XLEN-1:0]    wr_data,
    input  logic [1:0]         win_cmd,
    input  logic               ctl_wr_en,
    input  logic [CWP_W-1:0]   ctl_cwp,
    input  logic [NUM_WIN-1:0] ctl_wim,
    output logic [CWP_W-1:0]   cwp,
    output logic [NUM_WIN-1:0] wim,
    output logic               win_overflow,
    output logic               win_underflow
);
    localparam int unsigned PHYS_N = GROUP_SIZE + NUM_WIN * WIN_SPAN;
    localparam int unsigned PHYS_W = $clog2(PHYS_N);
    localparam int unsigned N_RD   = 2;
    localparam int unsigned N_MAP  = N_RD + 1;

    logic [CWP_W-1:0]  cwp_q;
    logic [IDX_W-1:0]  arch_idx [N_MAP];
    logic [PHYS_W-1:0] phys_idx [N_MAP];
    logic [PHYS_W-1:0] rd_phys  [N_RD];
    logic [XLEN-1:0]   rd_val   [N_RD];

    assign arch_idx[0] = rd_a_idx;
    assign arch_idx[1] = rd_b_idx;
    assign arch_idx[2] = wr_idx;

    // All three ports translate through the window that is current now,
    // so a write paired with a command lands in the pre-command window.
    for (genvar p = 0; p < N_MAP; p++) begin : g_map
        wrf_addr_map #(
            .CWP_W  (CWP_W),
            .PHYS_W (PHYS_W)
        ) i_map (
            .arch_idx (arch_idx[p]),
            .cur_win  (cwp_q),
            .phys_idx (phys_idx[p])
        );
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rdp
        assign rd_phys[p] = phys_idx[p];
    end

    wrf_window_ctrl #(
        .NUM_WIN   (NUM_WIN),
        .CWP_W     (CWP_W),
        .WIM_RESET (WIM_RESET)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (win_cmd),
        .ctl_wr_en (ctl_wr_en),
        .ctl_cwp   (ctl_cwp),
        .ctl_wim   (ctl_wim),
        .cwp_o     (cwp_q),
        .wim_o     (wim),
        .ovf_o     (win_overflow),
        .unf_o     (win_underflow)
    );

    wrf_storage #(
        .XLEN   (XLEN),
        .PHYS_N (PHYS_N),
        .PHYS_W (PHYS_W),
        .N_RD   (N_RD)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (phys_idx[N_MAP-1]),
        .wdata (wr_data),
        .raddr (rd_phys),
        .rdata (rd_val)
    );

    assign cwp       = cwp_q;
    assign rd_a_data = rd_val[0];
    assign rd_b_data = rd_val[1];
endmodule

// File: rtl/regwin_file_chk.sv
`timescale 1ns/1ps
module regwin_file_chk #(
    parameter int unsigned  NUM_WIN = 8,
    parameter int unsigned  XLEN    = 32,
    localparam int unsigned CWP_W   = $clog2(NUM_WIN)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [4:0]         rd_a_idx,
    input logic [XLEN-1:0]    rd_a_data,
    input logic [4:0]         rd_b_idx,
    input logic [XLEN-1:0]    rd_b_data,
    input logic               wr_en,
    input logic [4:0]         wr_idx,
    input logic [XLEN-1:0]    wr_data,
    input logic [1:0]         win_cmd,
    input logic               ctl_wr_en,
    input logic [CWP_W-1:0]   ctl_cwp,
    input logic [NUM_WIN-1:0] ctl_wim,
    input logic [CWP_W-1:0]   cwp,
    input logic [NUM_WIN-1:0] wim,
    input logic               win_overflow,
    input logic               win_underflow
);
    logic [CWP_W-1:0] below, above;
    assign below = cwp - CWP_W'(1);
    assign above = cwp + CWP_W'(1);

    a_r2_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
    a_r2_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
    a_r9_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != 5'd0 && rd_a_idx == wr_idx) |-> (rd_a_data == wr_data));
    a_r9_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != 5'd0 && rd_b_idx == wr_idx) |-> (rd_b_data == wr_data));
    a_r6_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_en && win_cmd == 2'b01 && !wim[below]) |=> (cwp == $past(below) && !win_overflow));
    a_r6_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_en && win_cmd == 2'b10 && !wim[above]) |=> (cwp == $past(above) && !win_underflow));
    a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_en && win_cmd == 2'b01 && wim[below]) |=> (win_overflow && cwp == $past(cwp)));
    a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_en && win_cmd == 2'b10 && wim[above]) |=> (win_underflow && cwp == $past(cwp)));
    a_r10_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> (cwp == $past(ctl_cwp) && wim == $past(ctl_wim)));
    a_r11_no_op: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_en && (win_cmd == 2'b11 || win_cmd == 2'b00))
            |=> ($stable(cwp) && $stable(wim) && !win_overflow && !win_underflow));
    a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_overflow && win_underflow));
endmodule

bind regwin_file regwin_file_chk #(.NUM_WIN(NUM_WIN), .XLEN(XLEN)) i_chk (.*);

// File: tb/test_regwin_file.sv
`timescale 1ns/1ps
module test_regwin_file;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, ctl_wr_en = 1'b0;
    logic [1:0]  win_cmd = 2'b00;
    logic [2:0]  ctl_cwp = '0, cwp;
    logic [7:0]  ctl_wim = '0, wim;
    logic        win_overflow, win_underflow;

    int n_checks = 0;
    int n_errors = 0;

    // Behavioural model: globals, per-window ins and locals
    logic [31:0] m_glob [8];
    logic [31:0] m_in   [NW][8];
    logic [31:0] m_loc  [NW][8];
    int          m_cwp;
    logic [7:0]  m_wim;
    bit          m_ovf, m_unf;

    always #2 clk = ~clk;

    regwin_file i_regwin_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .win_cmd(win_cmd), .ctl_wr_en(ctl_wr_en),
        .ctl_cwp(ctl_cwp), .ctl_wim(ctl_wim),
        .cwp(cwp), .wim(wim),
        .win_overflow(win_overflow), .win_underflow(win_underflow)
    );

    function automatic logic [31:0] m_read(int r);
        if (r == 0)       return 32'h0;
        else if (r < 8)   return m_glob[r];
        else if (r < 16)  return m_in[(m_cwp + NW - 1) % NW][r - 8];
        else if (r < 24)  return m_loc[m_cwp][r - 16];
        else              return m_in[m_cwp][r - 24];
    endfunction

    task automatic m_write(int r, logic [31:0] v);
        if (r == 0)       ;
        else if (r < 8)   m_glob[r] = v;
        else if (r < 16)  m_in[(m_cwp + NW - 1) % NW][r - 8] = v;
        else if (r < 24)  m_loc[m_cwp][r - 16] = v;
        else              m_in[m_cwp][r - 24] = v;
    endtask

    function automatic logic [31:0] exp_rd(int r);
        if (r != 0 && wr_en && int'(wr_idx) == r) return wr_data;
        return m_read(r);
    endfunction

    function automatic string rd_tag(int r);
        if (r != 0 && wr_en && int'(wr_idx) == r) return "R9 bypass";
        if (r == 0)  return "R2 zero reg";
        if (r < 8)   return "R3 global";
        if (r < 16)  return "R5 out";
        if (r < 24)  return "R4 local";
        return "R5 in";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_idx = '0; wr_data = '0;
        win_cmd = 2'b00; ctl_wr_en = 0; ctl_cwp = '0; ctl_wim = '0;
    endtask

    // Called at a falling edge with inputs set: compare, clock, update model.
    task automatic cycle();
        int t;
        #1;
        chk(rd_tag(int'(rd_a_idx)), rd_a_data, exp_rd(int'(rd_a_idx)));
        chk(rd_tag(int'(rd_b_idx)), rd_b_data, exp_rd(int'(rd_b_idx)));
        chk("R6 cwp", 32'(cwp), 32'(m_cwp));
        chk("R10 wim", 32'(wim), 32'(m_wim));
        chk("R7 overflow", 32'(win_overflow), 32'(m_ovf));
        chk("R8 underflow", 32'(win_underflow), 32'(m_unf));
        @(posedge clk);
        if (wr_en) m_write(int'(wr_idx), wr_data);   // R12: pre-command window
        m_ovf = 0; m_unf = 0;
        if (ctl_wr_en) begin
            m_cwp = int'(ctl_cwp); m_wim = ctl_wim;
        end else if (win_cmd == 2'b01) begin
            t = (m_cwp + NW - 1) % NW;
            if (m_wim[t]) m_ovf = 1; else m_cwp = t;
        end else if (win_cmd == 2'b10) begin
            t = (m_cwp + 1) % NW;
            if (m_wim[t]) m_unf = 1; else m_cwp = t;
        end
        @(negedge clk);
    endtask

    task automatic wr(int r, logic [31:0] v, logic [1:0] c);
        idle(); wr_en = 1; wr_idx = 5'(r); wr_data = v; win_cmd = c;
        rd_a_idx = 5'(r); rd_b_idx = 5'($urandom);
        cycle();
    endtask

    task automatic rd(int ra, int rb);
        idle(); rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
        cycle();
    endtask

    task automatic ctl(int c, logic [7:0] m, logic [1:0] cmd);
        idle(); ctl_wr_en = 1; ctl_cwp = 3'(c); ctl_wim = m; win_cmd = cmd;
        cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_glob[i] = '0;
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 8; i++) begin m_in[w][i] = '0; m_loc[w][i] = '0; end
        m_cwp = 0; m_wim = '0; m_ovf = 0; m_unf = 0;
        idle();
        repeat (3) @(negedge clk);
        rd_a_idx = 5'd17; rd_b_idx = 5'd9;
        #1;
        chk("R1 reset cwp", 32'(cwp), 32'd0);
        chk("R1 reset wim", 32'(wim), 32'd0);
        chk("R1 reset flags", 32'({win_overflow, win_underflow}), 32'd0);
        chk("R1 reset data", rd_a_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: write to register 0 is dropped
        wr(0, 32'hDEAD_BEEF, 2'b00);
        rd(0, 0);
        chk("R2 r0 after write", rd_a_data, 32'd0);

        // Fill every window with distinct values, stepping down with saves
        for (int w = 0; w < NW; w++) begin
            for (int r = 1; r < 32; r++) wr(r, {8'hA5, 8'(m_cwp), 8'(w), 8'(r)}, 2'b00);
            wr(3, 32'h0000_3000 + 32'(w), 2'b01);       // write global with a save
        end
        chk("R6 wrapped after NW saves", 32'(cwp), 32'd0);
        for (int r = 1; r < 32; r++) rd(r, 31 - r);

        // R3: global seen identically after moving window
        wr(5, 32'h5555_0005, 2'b00);
        rd(1, 1); rd(1, 1);
        ctl(4, 8'h00, 2'b00);
        rd(5, 0);
        chk("R3 global across windows", rd_a_data, 32'h5555_0005);

        // R5: out k in window 4 appears as in k in window 3 after save
        wr(11, 32'hC0FF_EE03, 2'b00);
        rd(0, 0);
        wr(20, 32'h1111_0004, 2'b01);                   // R12: local of window 4
        chk("R6 save step", 32'(cwp), 32'd3);
        rd(27, 0);
        chk("R5 out becomes in", rd_a_data, 32'hC0FF_EE03);
        // R4: local of window 3 differs from window 4
        wr(20, 32'h2222_0003, 2'b00);
        rd(1, 1);
        wr(0, 32'h0, 2'b10);
        rd(20, 0);
        chk("R12 write used pre-save window", rd_a_data, 32'h1111_0004);
        chk("R4 local private", rd_a_data, 32'h1111_0004);

        // R6 wrap on save from 0
        ctl(0, 8'h00, 2'b00);
        rd(0, 0);
        wr(0, 32'h0, 2'b01);
        chk("R6 wrap 0 to 7", 32'(cwp), 32'd7);
        wr(0, 32'h0, 2'b10);
        chk("R6 wrap 7 to 0", 32'(cwp), 32'd0);

        // R7 overflow at window 3 -> 2 invalid
        ctl(3, 8'b0000_0100, 2'b00);
        wr(0, 32'h0, 2'b01);
        chk("R7 overflow raised", 32'(win_overflow), 32'd1);
        chk("R7 cwp held", 32'(cwp), 32'd3);
        rd(0, 0);
        chk("R7 flag one cycle", 32'(win_overflow), 32'd0);

        // R8 underflow at window 1 -> 2 invalid
        ctl(1, 8'b0000_0100, 2'b00);
        wr(0, 32'h0, 2'b10);
        chk("R8 underflow raised", 32'(win_underflow), 32'd1);
        chk("R8 cwp held", 32'(cwp), 32'd1);

        // R10: control write wins over a save
        ctl(6, 8'b0000_0001, 2'b01);
        chk("R10 ctl priority cwp", 32'(cwp), 32'd6);
        chk("R10 ctl priority wim", 32'(wim), 32'd1);

        // R11: reserved command is a no-op
        idle(); win_cmd = 2'b11; cycle();
        chk("R11 reserved cmd", 32'(cwp), 32'd6);

        // R9 explicit bypass
        idle(); wr_en = 1; wr_idx = 5'd18; wr_data = 32'hB1B1_0018;
        rd_a_idx = 5'd18; rd_b_idx = 5'd18;
        #1;
        chk("R9 bypass port A", rd_a_data, 32'hB1B1_0018);
        chk("R9 bypass port B", rd_b_data, 32'hB1B1_0018);
        @(negedge clk); #0;
        rd(0, 0);
        // realign model: that write was clocked without cycle(), so replay it
        ctl(int'(cwp), wim, 2'b00);
        m_write(18, 32'hB1B1_0018);

        // Mixed traffic
        for (int n = 0; n < 4000; n++) begin
            idle();
            rd_a_idx = 5'($urandom); rd_b_idx = 5'($urandom);
            wr_en = 1'($urandom); wr_idx = 5'($urandom); wr_data = $urandom;
            if (($urandom % 3) == 0) rd_a_idx = wr_idx;
            win_cmd = 2'($urandom);
            if (($urandom % 40) == 0) begin
                ctl_wr_en = 1; ctl_cwp = 3'($urandom);
                ctl_wim = (($urandom % 2) == 0) ? 8'h00 : (8'h01 << ($urandom % 8));
            end
            cycle();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule